// File: doc/BRIEF.md
# Endian-Aware Word-to-Byte FIFO Packer

This block connects a 32-bit register port to two byte-wide queues, one outbound and one inbound. A register write is cut into bytes that go one per cycle into the outbound queue. A request to read the data register pulls bytes one per cycle out of the inbound queue and assembles them into a 32-bit result. An order input chooses whether byte traffic starts at the low end or the high end of the word. The queue storage sits outside the block, and the block sees only its full and empty flags.

The main data address moves a build-time number of bytes per access. Three more addresses move exactly one, two or three bytes. When the outbound queue fills during a write, the rest of the word is dropped. When the inbound queue runs dry during a read, the read finishes early with zeros in the unfilled lanes. Neither case raises an error.

The controller is a four-state machine. IDLE accepts commands and leaves on ACCEPT_WR (to PUSH, for a write that decodes to at least one byte) or ACCEPT_RD (to POP). PUSH moves one byte per cycle and returns to IDLE on PUSH_END, which is the last byte sent or the queue found full. POP takes one byte per cycle and moves to DONE on POP_END, which is the last byte taken or the queue found empty. DONE presents the assembled word for one cycle and returns to IDLE on RSP_SENT.

Top module: `word_byte_packer`

## Requirements
- R1: After reset the block is idle: busy, tx_push, rx_pop and rd_rsp_valid are all 0, and wr_ready is 1.
- R2: A write to the main data address (parameter MAIN_OFS, default 0x1C) pushes MAIN_BYTES bytes (1 to 4, default 1) when the outbound queue has room.
- R3: Writes to addresses 0x80, 0x84 and 0x88 push exactly 1, 2 and 3 bytes.
- R4: With cfg_msb_first = 0, the k-th pushed byte is wr_data[8k+7:8k]. With cfg_msb_first = 1, it is wr_data[31-8k:24-8k]. The order is sampled when the command is accepted.
- R5: No byte is pushed while tx_full is 1. When tx_full is found high, the write ends at once and its remaining bytes are dropped.
- R6: A read pops up to MAIN_BYTES bytes and stops at the first cycle in which rx_empty is 1. Lanes that receive no byte read as zero, and no pop happens while rx_empty is 1.
- R7: With cfg_msb_first = 0, the k-th popped byte lands in rd_data[8k+7:8k]. With cfg_msb_first = 1, it lands in rd_data[31-8k:24-8k].
- R8: At most one byte moves per cycle, and busy stays high for the whole sequence. While busy is high, wr_ready and rd_req_ready are 0, so a write with room for all its bytes keeps busy high for exactly as many cycles as it has bytes.
- R9: Each accepted read produces exactly one single-cycle rd_rsp_valid pulse, which carries the assembled word.
- R10: A write to any other address is accepted but pushes nothing and leaves busy low.
- R11: When wr_valid and rd_req_valid are high in the same idle cycle, the write is taken first and rd_req_ready is 0 in that cycle. The read is taken once the write has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_msb_first | input | 1 | Byte order: 1 starts at the most significant byte |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | ADDR_W | Register byte address of the write |
| wr_data | input | 32 | Write data word |
| rd_req_valid | input | 1 | Data register read request |
| rd_req_ready | output | 1 | Read request accepted this cycle |
| rd_rsp_valid | output | 1 | Read data valid (single-cycle pulse) |
| rd_data | output | 32 | Assembled read word |
| busy | output | 1 | A byte sequence is in progress |
| tx_push | output | 1 | Push strobe to the outbound queue |
| tx_byte | output | 8 | Byte being pushed |
| tx_full | input | 1 | Outbound queue full flag |
| rx_pop | output | 1 | Pop strobe to the inbound queue |
| rx_byte | input | 8 | Head byte of the inbound queue |
| rx_empty | input | 1 | Inbound queue empty flag |

## Verification
The bench writes one word in both byte orders through every width. A design that reverses the lane index only on the read side, or only on the write side, pushes or assembles the word mirrored. It fills the outbound queue to one byte short of 32 and then writes four bytes, so a design that keeps pushing past full, or stalls waiting for room, leaves the wrong byte count or hangs with busy high. Reads are made with two bytes available and with none, in both orders. A design that does not clear unfilled lanes returns stale data, and one that pops while empty corrupts the queue pointer. A simultaneous write and read catches a controller that drops one of the two commands or serves them in the wrong order.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_DONE = 2'd3
    } wbp_state_e;

endpackage

// File: rtl/wbp_addr_decode.sv
module wbp_addr_decode #(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 3,
    parameter int MAIN_BYTES = 1,
    parameter int MAIN_OFS   = 'h1C,
    parameter int PART1_OFS  = 'h80,
    parameter int PART2_OFS  = 'h84,
    parameter int PART3_OFS  = 'h88
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  nbytes
);
    always_comb begin
        if (addr == ADDR_W'(MAIN_OFS))       nbytes = CNT_W'(MAIN_BYTES);
        else if (addr == ADDR_W'(PART1_OFS)) nbytes = CNT_W'(1);
        else if (addr == ADDR_W'(PART2_OFS)) nbytes = CNT_W'(2);
        else if (addr == ADDR_W'(PART3_OFS)) nbytes = CNT_W'(3);
        else                                 nbytes = '0;
    end
endmodule

// File: rtl/wbp_byte_pick.sv
module wbp_byte_pick #(
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 3
) (
    input  logic [WORD_BYTES*8-1:0] word,
    input  logic [CNT_W-1:0]        idx,
    input  logic                    msb_first,
    output logic [7:0]              byte_out
);
    logic [CNT_W-1:0] lane;

    assign lane = msb_first ? CNT_W'(WORD_BYTES - 1) - idx : idx;

    always_comb begin
        byte_out = '0;
        for (int k = 0; k < WORD_BYTES; k++) begin
            if (lane == CNT_W'(k)) byte_out = word[k*8 +: 8];
        end
    end
endmodule

// File: rtl/wbp_lane_merge.sv
module wbp_lane_merge #(
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 3
) (
    input  logic [WORD_BYTES*8-1:0] acc_in,
    input  logic [7:0]              byte_in,
    input  logic [CNT_W-1:0]        idx,
    input  logic                    msb_first,
    output logic [WORD_BYTES*8-1:0] acc_out
);
    logic [CNT_W-1:0] lane;

    assign lane = msb_first ? CNT_W'(WORD_BYTES - 1) - idx : idx;

    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
        assign acc_out[k*8 +: 8] = (lane == CNT_W'(k)) ? byte_in : acc_in[k*8 +: 8];
    end
endmodule

// File: rtl/word_byte_packer.sv
module word_byte_packer
    import wbp_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_W     = 32,
    parameter int MAIN_BYTES = 1,
    parameter int MAIN_OFS   = 'h1C,
    parameter int PART1_OFS  = 'h80,
    parameter int PART2_OFS  = 'h84,
    parameter int PART3_OFS  = 'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_msb_first,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req_valid,
    output logic              rd_req_ready,
    output logic              rd_rsp_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [7:0]        rx_byte,
    input  logic              rx_empty
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int CNT_W      = $clog2(WORD_BYTES + 1);

    wbp_state_e        state, state_nxt;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_merged;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  idx_inc;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  wr_nbytes;
    logic              msb_q;
    logic              last_byte;

    assign idx_inc   = idx_q + CNT_W'(1);
    assign last_byte = (idx_inc == cnt_q);

    wbp_addr_decode #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .MAIN_BYTES(MAIN_BYTES),
        .MAIN_OFS  (MAIN_OFS),
        .PART1_OFS (PART1_OFS),
        .PART2_OFS (PART2_OFS),
        .PART3_OFS (PART3_OFS)
    ) u_decode (
        .addr  (wr_addr),
        .nbytes(wr_nbytes)
    );

    wbp_byte_pick #(
        .WORD_BYTES(WORD_BYTES),
        .CNT_W     (CNT_W)
    ) u_pick (
        .word     (word_q),
        .idx      (idx_q),
        .msb_first(msb_q),
        .byte_out (tx_byte)
    );

    wbp_lane_merge #(
        .WORD_BYTES(WORD_BYTES),
        .CNT_W     (CNT_W)
    ) u_merge (
        .acc_in   (acc_q),
        .byte_in  (rx_byte),
        .idx      (idx_q),
        .msb_first(msb_q),
        .acc_out  (acc_merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: ACCEPT_WR, ACCEPT_RD, PUSH_END, POP_END, RSP_SENT
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_valid) begin
                    if (wr_nbytes != '0) state_nxt = ST_PUSH;
                end else if (rd_req_valid) begin
                    state_nxt = ST_POP;
                end
            end
            ST_PUSH: if (tx_full || last_byte)  state_nxt = ST_IDLE;
            ST_POP:  if (rx_empty || last_byte) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        wr_ready     = (state == ST_IDLE);
        rd_req_ready = (state == ST_IDLE) && !wr_valid;
        tx_push      = (state == ST_PUSH) && !tx_full;
        rx_pop       = (state == ST_POP) && !rx_empty;
        rd_rsp_valid = (state == ST_DONE);
        rd_data      = acc_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            acc_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            msb_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx_q <= '0;
                    msb_q <= cfg_msb_first;
                    if (wr_valid) begin
                        word_q <= wr_data;
                        cnt_q  <= wr_nbytes;
                    end else if (rd_req_valid) begin
                        acc_q <= '0;
                        cnt_q <= CNT_W'(MAIN_BYTES);
                    end
                end
                ST_PUSH: if (!tx_full) idx_q <= idx_inc;
                ST_POP: begin
                    if (!rx_empty) begin
                        acc_q <= acc_merged;
                        idx_q <= idx_inc;
                    end
                end
                ST_DONE: idx_q <= '0;
                default: idx_q <= '0;
            endcase
        end
    end

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full); // R5
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty); // R6
    AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && rx_pop)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_push && !rx_pop && !rd_rsp_valid)); // R8
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!wr_ready && !rd_req_ready)); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid |=> !rd_rsp_valid); // R9
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_req_valid && !busy) |-> !rd_req_ready); // R11
endmodule

// File: tb/test_word_byte_packer.sv
module test_word_byte_packer;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_msb_first = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_req_valid = 1'b0;
    logic        rd_req_ready;
    logic        rd_rsp_valid;
    logic [31:0] rd_data;
    logic        busy;
    logic        tx_push;
    logic [7:0]  tx_byte;
    logic        tx_full;
    logic        rx_pop;
    logic [7:0]  rx_byte;
    logic        rx_empty;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // outbound queue model
    logic [7:0] tx_log [0:63];
    int         tx_cnt = 0;
    logic       tx_clr = 1'b0;
    assign tx_full = (tx_cnt >= 32);
    always @(posedge clk) begin
        if (tx_clr) tx_cnt <= 0;
        else if (tx_push) begin
            tx_log[tx_cnt[5:0]] <= tx_byte;
            tx_cnt <= tx_cnt + 1;
        end
    end

    // inbound queue model
    logic [7:0] rx_mem [0:63];
    logic [5:0] rx_wr = '0;
    logic [5:0] rx_rd = '0;
    logic       rx_ld = 1'b0;
    logic [7:0] rx_ld_byte = '0;
    logic       rx_clr = 1'b0;
    assign rx_empty = (rx_wr == rx_rd);
    assign rx_byte  = rx_mem[rx_rd];
    always @(posedge clk) begin
        if (rx_ld) begin
            rx_mem[rx_wr] <= rx_ld_byte;
            rx_wr <= rx_wr + 6'd1;
        end
        if (rx_clr) rx_rd <= rx_wr;
        else if (rx_pop) rx_rd <= rx_rd + 6'd1;
    end

    word_byte_packer #(.MAIN_BYTES(N)) i_word_byte_packer (
        .clk(clk), .rst_n(rst_n), .cfg_msb_first(cfg_msb_first),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_data(rd_data), .busy(busy),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty)
    );

    int busy_cycles;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_tx();
        @(negedge clk); tx_clr = 1'b1;
        @(negedge clk); tx_clr = 1'b0;
    endtask

    task automatic load_rx(input logic [7:0] b);
        @(negedge clk); rx_ld = 1'b1; rx_ld_byte = b;
        @(negedge clk); rx_ld = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic msb);
        @(negedge clk);
        cfg_msb_first = msb; wr_addr = a; wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        busy_cycles = 0;
        for (int i = 0; i < 40 && busy; i++) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input logic msb, output logic [31:0] d);
        @(negedge clk);
        cfg_msb_first = msb; rd_req_valid = 1'b1;
        @(negedge clk);
        rd_req_valid = 1'b0;
        d = 32'hDEAD_BEEF;
        for (int i = 0; i < 40 && !rd_rsp_valid; i++) @(negedge clk);
        if (rd_rsp_valid) d = rd_data;
        @(negedge clk);
        check("R9 single response pulse", {31'd0, rd_rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 tx_push", {31'd0, tx_push}, 32'd0);
        check("R1 rx_pop", {31'd0, rx_pop}, 32'd0);
        check("R1 rd_rsp_valid", {31'd0, rd_rsp_valid}, 32'd0);
        check("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    endtask

    task automatic t_main_write();
        clear_tx();
        do_write(8'h1C, 32'hA1B2C3D4, 1'b0);
        check("R2 main byte count", tx_cnt, 4);
        check("R8 busy cycles", busy_cycles, 4);
        check("R4 little order", {tx_log[0], tx_log[1], tx_log[2], tx_log[3]}, 32'hD4C3B2A1);
        clear_tx();
        do_write(8'h1C, 32'hA1B2C3D4, 1'b1);
        check("R4 big order", {tx_log[0], tx_log[1], tx_log[2], tx_log[3]}, 32'hA1B2C3D4);
    endtask

    task automatic t_partial();
        clear_tx();
        do_write(8'h80, 32'h11223344, 1'b1);
        check("R3 one byte count", tx_cnt, 1);
        check("R3 R4 one byte big", {24'd0, tx_log[0]}, 32'h11);
        clear_tx();
        do_write(8'h84, 32'h11223344, 1'b1);
        check("R3 two byte count", tx_cnt, 2);
        check("R3 R4 two bytes big", {16'd0, tx_log[0], tx_log[1]}, 32'h1122);
        clear_tx();
        do_write(8'h88, 32'h11223344, 1'b0);
        check("R3 three byte count", tx_cnt, 3);
        check("R3 R4 three bytes little", {8'd0, tx_log[0], tx_log[1], tx_log[2]}, 32'h443322);
    endtask

    task automatic t_other_addr();
        clear_tx();
        do_write(8'h40, 32'hFFFF_FFFF, 1'b0);
        check("R10 no busy", busy_cycles, 0);
        check("R10 no push", tx_cnt, 0);
    endtask

    task automatic t_full();
        clear_tx();
        for (int i = 0; i < 7; i++) do_write(8'h1C, 32'h01010101 * (i + 1), 1'b0);
        do_write(8'h88, 32'h00AABBCC, 1'b0);
        check("R5 filled to 31", tx_cnt, 31);
        do_write(8'h1C, 32'h55667788, 1'b0);
        check("R5 stopped at full", tx_cnt, 32);
        check("R5 last byte kept", {24'd0, tx_log[31]}, 32'h88);
        check("R5 ended after one push", busy_cycles, 2);
        do_write(8'h84, 32'h12345678, 1'b1);
        check("R5 no push when full", tx_cnt, 32);
        check("R5 dropped write ends", {31'd0, busy}, 32'd0);
        clear_tx();
    endtask

    task automatic t_read();
        logic [31:0] d;
        for (int i = 1; i <= 4; i++) load_rx(8'(i));
        do_read(1'b0, d);
        check("R6 R7 little full read", d, 32'h04030201);
        for (int i = 1; i <= 4; i++) load_rx(8'(i));
        do_read(1'b1, d);
        check("R6 R7 big full read", d, 32'h01020304);
        load_rx(8'hA1); load_rx(8'hB2);
        do_read(1'b0, d);
        check("R6 little short read", d, 32'h0000B2A1);
        load_rx(8'hA1); load_rx(8'hB2);
        do_read(1'b1, d);
        check("R6 big short read", d, 32'hA1B20000);
        do_read(1'b1, d);
        check("R6 empty read zero", d, 32'h0);
        check("R6 queue drained", {31'd0, rx_empty}, 32'd1);
    endtask

    task automatic t_both();
        logic [31:0] d;
        clear_tx();
        load_rx(8'h5A);
        @(negedge clk);
        cfg_msb_first = 1'b0; wr_addr = 8'h84; wr_data = 32'h0000CAFE;
        wr_valid = 1'b1; rd_req_valid = 1'b1;
        #1;
        check("R11 read held off", {31'd0, rd_req_ready}, 32'd0);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int i = 0; i < 40 && !rd_req_ready; i++) @(negedge clk);
        check("R11 write done first", tx_cnt, 2);
        @(negedge clk);
        rd_req_valid = 1'b0;
        d = 32'hDEAD_BEEF;
        for (int i = 0; i < 40 && !rd_rsp_valid; i++) @(negedge clk);
        if (rd_rsp_valid) d = rd_data;
        check("R11 read served after", d, 32'h0000005A);
        check("R11 bytes", {16'd0, tx_log[0], tx_log[1]}, 32'hFECA);
    endtask

    initial begin
        tx_clr = 1'b1;
        rx_clr = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        tx_clr = 1'b0;
        rx_clr = 1'b0;
        t_reset();
        t_main_write();
        t_partial();
        t_other_addr();
        t_full();
        t_read();
        t_both();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule